// File: doc/BRIEF.md
# Reconfigurable Two-Stage Product Fabric

This block is a programmable logic array. It computes up to `N_OUT` Boolean outputs from `N_IN` inputs through `N_PROD` product rows. Every crosspoint in the array holds a two-bit mode that sets when the crosspoint lets its row through, based on the control signal that crosses it. In the first stage, each row forms the AND of its crosspoints, with the inputs as controls. The second stage uses the same cell type, with the first-stage products as controls. Each output row therefore forms an AND over the inverted products it selects. To implement a target function, program the rows with the product terms that make each output 0. Stage two then returns the complement of their sum.

The path from inputs to outputs is purely combinational. The only state is the mode storage. It is written one cell per clock through a matrix address: a row number and a column number. Rows `0..N_PROD-1` are product rows, and their columns index the inputs. Rows `N_PROD..N_PROD+N_OUT-1` are output rows, and their columns index the products. Changing only the stored modes and the meaning of the pins makes one instance act as a priority encoder, a selector or a one-hot steering element.

Top module: `prod_fabric`

## Requirements
- R1: A synchronous reset sets every stored mode to 2'b11, so every product and every output reads 0 on the cycle after reset.
- R2: The mode codes are as follows. 2'b00 always passes. 2'b01 passes only when its control is 1. 2'b10 passes only when its control is 0. 2'b11 never passes.
- R3: Product row r is 1 exactly when all `N_IN` crosspoints of row r pass, with input bit c as the control of column c.
- R4: Output k is 1 exactly when all `N_PROD` crosspoints of row `N_PROD+k` pass, with product p as the control of column p. Programming 2'b10 on a product selects it and 2'b00 ignores it, so the output is the AND of the inverted selected products.
- R5: When `cfg_we` is 1 and the address is valid, `cfg_mode` replaces the addressed cell at the next rising clock edge. Outputs before that edge still follow the old mode, and no other cell changes.
- R6: A write is ignored in three cases: a row number of `N_PROD+N_OUT` or above, a product-row column of `N_IN` or above, or an output-row column of `N_PROD` or above. Outputs stay as they were.
- R7: Outputs follow a change of `x_in` within the same clock cycle, with no clock edge in between.
- R8: Configured as a priority encoder, the fabric gives the index of the highest set bit on `y_out[2:0]`. The data is on `x_in[7:0]`, the result is 0 when all data bits are 0, `y_out[7:3]` is 0, and `x_in[11:8]` has no effect.
- R9: Configured as an 8-to-1 selector, with select on `x_in[10:8]` and data on `x_in[7:0]`, `y_out[0]` equals the data bit at the select index.
- R10: Configured as a 1-to-8 steering element, with data on `x_in[0]` and select on `x_in[3:1]`, `y_out` equals the data bit shifted left by the select value.
- R11: A product row left in 2'b11 adds no term. Selecting it on an output row does not change that output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for mode storage |
| rst | input | 1 | Synchronous reset, sets every cell to 2'b11 |
| cfg_we | input | 1 | Mode write enable |
| cfg_row | input | ROW_W | Row address (product rows first, then output rows) |
| cfg_col | input | COL_W | Column address within the row |
| cfg_mode | input | 2 | Mode code to store |
| x_in | input | N_IN | Logic inputs, controls of stage one |
| y_out | output | N_OUT | Logic outputs of stage two |

## Verification
A mode write and an evaluation can fall in the same cycle. The write changes a cell whose row is active for the current input pattern. The bench sets up a selector configuration and holds an input on which output 0 is 1. In that same cycle it issues a write that turns the active row's data crosspoint from pass-on-0 into pass-on-1. The output is sampled after the write is presented but before the edge, where it must still show the old result. It is sampled again just after the edge, where it must show the new result. Any leak of the write data into evaluation before the edge, and any missed update after it, shows up as a mismatch.

// File: rtl/pf_pkg.sv
package pf_pkg;

   typedef enum logic [1:0] {
      XP_THRU    = 2'b00,
      XP_ON_HIGH = 2'b01,
      XP_ON_LOW  = 2'b10,
      XP_SHUT    = 2'b11
   } xp_mode_e;

   function automatic logic xp_pass(input xp_mode_e m, input logic ctl);
      unique case (m)
         XP_THRU:    xp_pass = 1'b1;
         XP_ON_HIGH: xp_pass = ctl;
         XP_ON_LOW:  xp_pass = ~ctl;
         default:    xp_pass = 1'b0;
      endcase
   endfunction

   function automatic int pf_bits(input int n);
      pf_bits = (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pf_cfg_bank.sv
module pf_cfg_bank #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter int BASE  = 0,
   parameter int ROW_W = 3,
   parameter int COL_W = 2
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             we,
   input  logic [ROW_W-1:0]                 row,
   input  logic [COL_W-1:0]                 col,
   input  logic [1:0]                       mode,
   output logic [ROWS-1:0][COLS-1:0][1:0]   modes_q
);
   import pf_pkg::*;

   localparam int LAST_ROW = BASE + ROWS - 1;

   generate
      if (LAST_ROW >= (1 << ROW_W)) begin : g_bad_rows
         $error("pf_cfg_bank: row range does not fit ROW_W");
      end
      if (COLS > (1 << COL_W)) begin : g_bad_cols
         $error("pf_cfg_bank: COLS does not fit COL_W");
      end
   endgenerate

   // R5/R6: each cell decodes only its own address; other addresses never match
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic row_hit;
      assign row_hit = we && (row == ROW_W'(BASE + r));
      for (genvar c = 0; c < COLS; c++) begin : g_col
         always_ff @(posedge clk) begin
            if (rst)
               modes_q[r][c] <= XP_SHUT;     // R1
            else if (row_hit && (col == COL_W'(c)))
               modes_q[r][c] <= mode;
         end
      end
   end

endmodule

// File: rtl/pf_plane.sv
module pf_plane #(
   parameter int ROWS  = 4,
   parameter int COLS  = 4,
   parameter bit CHAIN = 1'b0
) (
   input  logic [COLS-1:0]                ctl,
   input  logic [ROWS-1:0][COLS-1:0][1:0] modes,
   output logic [ROWS-1:0]                row_out
);
   import pf_pkg::*;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] pass_v;
      for (genvar c = 0; c < COLS; c++) begin : g_cell
         assign pass_v[c] = xp_pass(xp_mode_e'(modes[r][c]), ctl[c]);   // R2
      end
      if (CHAIN) begin : g_chain
         // light-path form: the row stays lit only while every cell passes
         logic [COLS:0] lit;
         assign lit[0] = 1'b1;
         for (genvar c = 0; c < COLS; c++) begin : g_link
            assign lit[c+1] = lit[c] & pass_v[c];
         end
         assign row_out[r] = lit[COLS];
      end else begin : g_tree
         assign row_out[r] = &pass_v;          // R3/R4
      end
   end

endmodule

// File: rtl/prod_fabric.sv
module prod_fabric #(
   parameter int N_IN   = 12,
   parameter int N_PROD = 16,
   parameter int N_OUT  = 8,
   parameter bit CHAIN1 = 1'b0,
   parameter bit CHAIN2 = 1'b1,
   localparam int ROW_W = pf_pkg::pf_bits(N_PROD + N_OUT),
   localparam int COL_W = pf_pkg::pf_bits((N_IN > N_PROD) ? N_IN : N_PROD)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [ROW_W-1:0] cfg_row,
   input  logic [COL_W-1:0] cfg_col,
   input  logic [1:0]       cfg_mode,
   input  logic [N_IN-1:0]  x_in,
   output logic [N_OUT-1:0] y_out
);

   generate
      if (N_IN < 1 || N_PROD < 1 || N_OUT < 1) begin : g_bad_dims
         $error("prod_fabric: every dimension must be at least 1");
      end
   endgenerate

   logic [N_PROD-1:0][N_IN-1:0][1:0]   s1_modes;
   logic [N_OUT-1:0][N_PROD-1:0][1:0]  s2_modes;
   logic [N_PROD-1:0]                  prod_w;

   pf_cfg_bank #(
      .ROWS(N_PROD), .COLS(N_IN), .BASE(0), .ROW_W(ROW_W), .COL_W(COL_W)
   ) u_bank_s1 (
      .clk(clk), .rst(rst), .we(cfg_we), .row(cfg_row), .col(cfg_col),
      .mode(cfg_mode), .modes_q(s1_modes)
   );

   pf_cfg_bank #(
      .ROWS(N_OUT), .COLS(N_PROD), .BASE(N_PROD), .ROW_W(ROW_W), .COL_W(COL_W)
   ) u_bank_s2 (
      .clk(clk), .rst(rst), .we(cfg_we), .row(cfg_row), .col(cfg_col),
      .mode(cfg_mode), .modes_q(s2_modes)
   );

   // stage one: products of the inputs
   pf_plane #(.ROWS(N_PROD), .COLS(N_IN), .CHAIN(CHAIN1)) u_plane_s1 (
      .ctl(x_in), .modes(s1_modes), .row_out(prod_w)
   );

   // stage two: same cell, products as controls (AND of inverted selections)
   pf_plane #(.ROWS(N_OUT), .COLS(N_PROD), .CHAIN(CHAIN2)) u_plane_s2 (
      .ctl(prod_w), .modes(s2_modes), .row_out(y_out)
   );

endmodule

// File: rtl/prod_fabric_chk.sv
module prod_fabric_chk #(
   parameter int N_IN   = 12,
   parameter int N_PROD = 16,
   parameter int N_OUT  = 8,
   parameter int ROW_W  = 5,
   parameter int COL_W  = 4
) (
   input logic                              clk,
   input logic                              rst,
   input logic                              cfg_we,
   input logic [ROW_W-1:0]                  cfg_row,
   input logic [COL_W-1:0]                  cfg_col,
   input logic [1:0]                        cfg_mode,
   input logic [N_IN-1:0]                   x_in,
   input logic [N_PROD-1:0]                 prod_w,
   input logic [N_OUT-1:0]                  y_out,
   input logic [N_PROD-1:0][N_IN-1:0][1:0]  s1_modes,
   input logic [N_OUT-1:0][N_PROD-1:0][1:0] s2_modes
);

   logic pv = 1'b0;
   always @(posedge clk) pv <= 1'b1;

   int  row_i, col_i;
   logic in_range;
   always_comb begin
      row_i = int'(cfg_row);
      col_i = int'(cfg_col);
      if (row_i < N_PROD)               in_range = (col_i < N_IN);
      else if (row_i < N_PROD + N_OUT)  in_range = (col_i < N_PROD);
      else                              in_range = 1'b0;
   end

   logic             l_hit = 1'b0;
   logic [ROW_W-1:0] l_row = '0;
   logic [COL_W-1:0] l_col = '0;
   logic [1:0]       l_mode = '0;
   always @(posedge clk) begin
      l_hit  <= cfg_we && !rst && in_range;
      l_row  <= cfg_row;
      l_col  <= cfg_col;
      l_mode <= cfg_mode;
   end

   logic [1:0] at_l;
   always_comb begin
      at_l = 2'b00;
      for (int r = 0; r < N_PROD; r++)
         for (int c = 0; c < N_IN; c++)
            if (int'(l_row) == r && int'(l_col) == c) at_l = s1_modes[r][c];
      for (int k = 0; k < N_OUT; k++)
         for (int p = 0; p < N_PROD; p++)
            if (int'(l_row) == N_PROD + k && int'(l_col) == p) at_l = s2_modes[k][p];
   end

   logic [N_PROD-1:0] row_dead;
   always_comb begin
      for (int r = 0; r < N_PROD; r++) begin
         row_dead[r] = 1'b0;
         for (int c = 0; c < N_IN; c++)
            if (s1_modes[r][c] == 2'b11 || (s1_modes[r][c] == 2'b01 && !x_in[c]))
               row_dead[r] = 1'b1;
      end
   end

   assert_reset_blank_R1: assert property (@(posedge clk) disable iff (rst)
      pv && $past(rst) |-> (y_out == '0) && (prod_w == '0));

   assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
      pv && l_hit |-> at_l == l_mode);

   assert_bad_addr_ignored_R6: assert property (@(posedge clk) disable iff (rst)
      pv && !$past(rst) && $past(cfg_we && !in_range) |->
         $stable(s1_modes) && $stable(s2_modes));

   for (genvar r = 0; r < N_PROD; r++) begin : g_prod
      assert_dead_row_low_R3: assert property (@(posedge clk) disable iff (rst)
         row_dead[r] |-> !prod_w[r]);
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out
      for (genvar p = 0; p < N_PROD; p++) begin : g_sel
         assert_selected_kills_R4: assert property (@(posedge clk) disable iff (rst)
            (s2_modes[k][p] == 2'b10) && prod_w[p] |-> !y_out[k]);
      end
   end

endmodule

bind prod_fabric prod_fabric_chk #(
   .N_IN(N_IN), .N_PROD(N_PROD), .N_OUT(N_OUT), .ROW_W(ROW_W), .COL_W(COL_W)
) u_chk (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
   .cfg_mode(cfg_mode), .x_in(x_in), .prod_w(prod_w), .y_out(y_out),
   .s1_modes(s1_modes), .s2_modes(s2_modes)
);

// File: tb/prod_fabric_test.sv
`timescale 1ns/1ps
module prod_fabric_test;
   localparam int NI = 12;
   localparam int NP = 16;
   localparam int NO = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_we = 1'b0;
   logic [4:0]    cfg_row = '0;
   logic [3:0]    cfg_col = '0;
   logic [1:0]    cfg_mode = '0;
   logic [NI-1:0] x_in = '0;
   logic [NO-1:0] y_out;

   always #2.5 clk = ~clk;

   prod_fabric uut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row), .cfg_col(cfg_col),
      .cfg_mode(cfg_mode), .x_in(x_in), .y_out(y_out)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [NO-1:0] exp_q[$];
   string         req_q[$];

   task automatic chk(input string req, input logic [NO-1:0] got, input logic [NO-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: y_out=%h expected %h at %0t", req, got, exp, $time);
      end
   endtask

   // monitor: compares the design against the queued expectation
   always @(negedge clk) begin
      if (exp_q.size() > 0) chk(req_q.pop_front(), y_out, exp_q.pop_front());
   end

   // driver: apply an input and queue its expected output
   task automatic drive(input logic [NI-1:0] v, input logic [NO-1:0] exp, input string req);
      @(posedge clk); #0.5;
      x_in = v;
      exp_q.push_back(exp);
      req_q.push_back(req);
      @(negedge clk); #0.5;
   endtask

   task automatic wr(input int row, input int col, input logic [1:0] m);
      @(negedge clk); #0.5;
      cfg_we = 1'b1; cfg_row = 5'(row); cfg_col = 4'(col); cfg_mode = m;
      @(posedge clk); #0.5;
      cfg_we = 1'b0;
   endtask

   task automatic do_reset();
      @(posedge clk); #0.5; rst = 1'b1;
      @(posedge clk); #0.5; rst = 1'b0;
   endtask

   task automatic prog_prod(input int r, input logic [NI-1:0] care, input logic [NI-1:0] val);
      for (int c = 0; c < NI; c++)
         wr(r, c, !care[c] ? 2'b00 : (val[c] ? 2'b01 : 2'b10));
   endtask

   task automatic prog_out(input int k, input logic [NP-1:0] sel);
      for (int p = 0; p < NP; p++) wr(NP + k, p, sel[p] ? 2'b10 : 2'b00);
   endtask

   function automatic logic [NO-1:0] top_index(input logic [7:0] d);
      logic [NO-1:0] r = '0;
      for (int i = 0; i < 8; i++) if (d[i]) r = NO'(i);
      return r;
   endfunction

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         summary();
      end
   end

   initial begin
      do_reset();
      // R1: everything blocked after reset
      drive('1, '0, "R1");
      drive(12'h5A3, '0, "R1");

      // R2: one product row, one active cell of each mode, output 0 = ~product 0
      prog_out(0, 16'h0001);
      prog_prod(0, '0, '0);
      for (int m = 0; m < 4; m++) begin
         wr(0, 0, 2'(m));
         for (int b = 0; b < 2; b++) begin
            logic p;
            p = (m == 0) ? 1'b1 : (m == 1) ? b[0] : (m == 2) ? ~b[0] : 1'b0;
            drive({11'h5A3, b[0]}, {7'b0, ~p}, "R2");
         end
      end

      // R8: priority encoder (R3/R4 through the product and output rows)
      do_reset();
      for (int i = 0; i < 8; i++)
         prog_prod(i, 12'(8'hFF & ~((1 << i) - 1)), 12'(1 << i));
      prog_prod(8, 12'h0FF, 12'h000);
      for (int b = 0; b < 3; b++) begin
         logic [NP-1:0] sel = '0;
         for (int i = 0; i < 9; i++) if (((i == 8) ? 0 : i) >> b & 1) sel[i] = 1'b0; else sel[i] = 1'b1;
         prog_out(b, sel);
      end
      for (int v = 0; v < 256; v++)
         drive({4'(v * 7), 8'(v)}, top_index(8'(v)), "R8");

      // R9: 8-to-1 selector
      do_reset();
      for (int j = 0; j < 8; j++) prog_prod(j, 12'h700 | 12'(1 << j), 12'(j << 8));
      prog_out(0, 16'h00FF);
      foreach (pat_list[i]) ;
      for (int s = 0; s < 8; s++)
         for (int q = 0; q < 4; q++) begin
            logic [7:0] d;
            d = (q == 0) ? 8'hA5 : (q == 1) ? 8'h3C : (q == 2) ? 8'h00 : 8'hFF;
            drive({1'b0, 3'(s), d}, {7'b0, d[s]}, "R9");
         end

      // R11: select an unused (still shut) row on output 0, no change
      wr(NP + 0, 12, 2'b10);
      drive({1'b0, 3'd5, 8'h20}, 8'h01, "R11");
      drive({1'b0, 3'd5, 8'hDF}, 8'h00, "R11");

      // R6: out-of-range row, and a product-row column past N_IN
      wr(NP + NO, 0, 2'b11);
      wr(0, 13, 2'b11);
      drive({1'b0, 3'd0, 8'h01}, 8'h01, "R6");
      drive({1'b0, 3'd3, 8'h08}, 8'h01, "R6");

      // R7: output follows input inside the cycle, no edge in between
      @(posedge clk); #0.5;
      x_in = {1'b0, 3'd2, 8'h04};
      #1.0 chk("R7", y_out, 8'h01);
      x_in = {1'b0, 3'd2, 8'hFB};
      #0.5 chk("R7", y_out, 8'h00);

      // R5: write and evaluation in the same cycle
      drive({1'b0, 3'd0, 8'h01}, 8'h01, "R5");
      @(negedge clk); #0.5;
      cfg_we = 1'b1; cfg_row = 5'd0; cfg_col = 4'd0; cfg_mode = 2'b01;
      #1.0 chk("R5", y_out, 8'h01);
      @(posedge clk); #0.5;
      cfg_we = 1'b0;
      chk("R5", y_out, 8'h00);
      wr(0, 0, 2'b10);
      drive({1'b0, 3'd0, 8'h01}, 8'h01, "R5");

      // R10: 1-to-8 steering
      do_reset();
      prog_prod(0, 12'h001, 12'h000);
      for (int j = 0; j < 8; j++) prog_prod(j + 1, 12'h00E, 12'(j << 1));
      for (int k = 0; k < NO; k++) prog_out(k, 16'h01FF & ~16'(1 << (k + 1)));
      for (int s = 0; s < 8; s++)
         for (int d = 0; d < 2; d++)
            drive({8'h00, 3'(s), d[0]}, NO'(d) << s, "R10");

      // R1 again: reset clears a loaded configuration
      do_reset();
      drive({8'h00, 3'd4, 1'b1}, '0, "R1");

      done = 1'b1;
      summary();
   end

   int pat_list[1] = '{0};

endmodule